// File: doc/BRIEF.md
# Power-Up Self-Test Gate

This block stands between a cryptographic engine and the traffic that feeds it. When reset is released it runs a fixed list of seven known-answer tests with no command from anyone. For each test it sends a single-cycle start request, together with the test number and a key-size tag, to an external algorithm engine. It then waits for a done pulse that carries a pass/fail result. The engine itself and its test vectors are outside the block.

Until every test has passed, the block closes the input data stream, the output data stream and the command path. When the last test passes, the block raises an operational flag and opens all three paths. A failed test or a silent engine puts the block in a locked error state. The failure bit and the number of the failing test stay set until the next reset. A reset clears the error and runs the whole list again from the first test.

Both data paths are valid/ready streams. The gate adds no storage to them. When a path is open, valid goes downstream and ready goes upstream unchanged and in the same cycle, so back-pressure passes straight through. When a path is closed, the downstream valid and the upstream ready are both held low and the data lines are driven to zero, so no transfer can occur on either side.

Top module: `selftest_gate`

## Requirements
- R1: Tests start automatically. After the first rising clock edge that follows reset release, `eng_start` is high in the next cycle with `eng_slot` = 0, and no input is needed to cause it.
- R2: Tests are requested in a fixed order, with `eng_slot` giving the test number: 0 AES-CCM, 1 AES-ECB, 2 AES-CMAC, 3 HMAC-SHA-1, 4 HMAC-SHA2-256, 5 HMAC-SHA2-512, 6 HMAC-SHA3-512. Each `eng_start` pulse lasts one cycle. The next test is requested only in the cycle after a cycle in which the block is waiting and sees `eng_done` and `eng_pass` both high.
- R3: With every start pulse, `eng_keysz` is 0 (256-bit key) for tests 0 to 2 and 1 (512-bit key) for tests 3 to 6.
- R4: A done pulse is taken into account only in a cycle where the block is waiting for a result. A done pulse at any other time changes nothing.
- R5: While the block is not operational, the gated outputs are all held low: `core_in_valid`, `din_ready`, `dout_valid`, `core_out_ready` and `core_cmd_valid`. `core_in_data`, `dout_data` and `core_cmd_code` are driven to zero.
- R6: While the block is operational, each stream passes through combinationally: valid and data go downstream, and ready comes back upstream in the same cycle. The command valid and code pass through the same way.
- R7: The operational bit (`status[1]`) rises, and the busy bit (`status[0]`) falls, in the cycle after test 6 reports a pass.
- R8: If a waiting cycle sees `eng_done` high with `eng_pass` low, the block enters the error state in the next cycle. In the error state `status[2]` = 1, `status[1:0]` = 0, and `status[5:3]` holds the number of the failing test.
- R9: The error state is left only by reset. Commands, stream traffic and further done pulses do not change the status or open any path.
- R10: Each test may wait at most WDOG_CYCLES cycles. If the WDOG_CYCLES-th waiting cycle has no done pulse, the block fails that test exactly as in R8. A done pulse that arrives in that last cycle is still accepted.
- R11: Reset is asynchronous and active low. During reset, status = 6'b000001 (busy only), and a new run begins at test 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eng_start | output | 1 | One-cycle start request to the test engine |
| eng_slot | output | 3 | Number of the test being requested |
| eng_keysz | output | 1 | Key-size tag: 0 = 256-bit, 1 = 512-bit |
| eng_done | input | 1 | Engine result pulse |
| eng_pass | input | 1 | Test result, valid together with eng_done |
| din_valid | input | 1 | Upstream input stream valid |
| din_data | input | DATA_W | Upstream input stream data |
| din_ready | output | 1 | Upstream input stream ready (gated) |
| core_in_valid | output | 1 | Input stream valid toward the engine (gated) |
| core_in_data | output | DATA_W | Input stream data toward the engine (zero when closed) |
| core_in_ready | input | 1 | Engine ready on the input stream |
| core_out_valid | input | 1 | Engine output stream valid |
| core_out_data | input | DATA_W | Engine output stream data |
| core_out_ready | output | 1 | Ready toward the engine output (gated) |
| dout_valid | output | 1 | Downstream output valid (gated) |
| dout_data | output | DATA_W | Downstream output data (zero when closed) |
| dout_ready | input | 1 | Downstream output ready |
| cmd_valid | input | 1 | Service command strobe |
| cmd_code | input | CMD_W | Service command code |
| core_cmd_valid | output | 1 | Command strobe toward the engine (gated) |
| core_cmd_code | output | CMD_W | Command code toward the engine (zero when closed) |
| status | output | 6 | [0] busy, [1] operational, [2] failed, [5:3] failing test number |

## Verification
The engine is replaced by a stub, and each test slot has its own response latency and result. Runs where every test passes at mixed latencies check the order, the key-size tags and the moment the block opens. Single failures at the first, a middle and the last test check that the recorded test number is right. A hung slot and a slot that answers in exactly the last allowed cycle separate the watchdog's timeout from its acceptance edge. Throughout all of these, toggling stream and command inputs show whether any path leaks while closed or gets delayed while open. Stray done pulses while operational and while in error show whether they are ignored.

// File: rtl/stg_pkg.sv
package stg_pkg;

  typedef enum logic [2:0] {
    SQ_RESET = 3'd0,
    SQ_RUN   = 3'd1,
    SQ_WAIT  = 3'd2,
    SQ_OPER  = 3'd3,
    SQ_ERR   = 3'd4
  } sq_state_e;

  // Tests numbered below num_short use the short (256-bit) key.
  function automatic logic key_tag(input int slot, input int num_short);
    return slot >= num_short;
  endfunction

endpackage

// File: rtl/stg_watchdog.sv
module stg_watchdog #(
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!armed) cnt <= '0;
    else             cnt <= cnt + CW'(1);
  end

  // High during the LIMIT-th armed cycle.
  assign expired = armed && (cnt == LAST);
endmodule

// File: rtl/stg_sequencer.sv
module stg_sequencer
  import stg_pkg::*;
#(
  parameter int NUM_TESTS = 7,
  parameter int IDX_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eng_done,
  input  logic             eng_pass,
  input  logic             wd_expired,
  output sq_state_e        state,
  output logic [IDX_W-1:0] slot_idx,
  output logic [IDX_W-1:0] fail_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_TESTS - 1);

  sq_state_e        nxt;
  logic [IDX_W-1:0] idx_nxt;
  logic [IDX_W-1:0] fidx_nxt;

  always_comb begin
    nxt      = state;
    idx_nxt  = slot_idx;
    fidx_nxt = fail_idx;
    unique case (state)
      SQ_RESET: begin
        idx_nxt = '0;
        nxt     = SQ_RUN;
      end
      SQ_RUN:  nxt = SQ_WAIT;
      SQ_WAIT: begin
        if (eng_done) begin
          if (!eng_pass) begin
            nxt      = SQ_ERR;
            fidx_nxt = slot_idx;
          end else if (slot_idx == LAST) begin
            nxt = SQ_OPER;
          end else begin
            idx_nxt = slot_idx + IDX_W'(1);
            nxt     = SQ_RUN;
          end
        end else if (wd_expired) begin
          nxt      = SQ_ERR;
          fidx_nxt = slot_idx;
        end
      end
      default: ;  // operational and error hold until reset
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SQ_RESET;
      slot_idx <= '0;
      fail_idx <= '0;
    end else begin
      state    <= nxt;
      slot_idx <= idx_nxt;
      fail_idx <= fidx_nxt;
    end
  end
endmodule

// File: rtl/stg_stream_gate.sv
module stg_stream_gate #(
  parameter int W = 32
) (
  input  logic         open,
  input  logic         src_valid,
  input  logic [W-1:0] src_data,
  output logic         src_ready,
  output logic         dst_valid,
  output logic [W-1:0] dst_data,
  input  logic         dst_ready
);
  assign dst_valid = open & src_valid;
  assign dst_data  = open ? src_data : '0;
  assign src_ready = open & dst_ready;
endmodule

// File: rtl/selftest_gate.sv
module selftest_gate
  import stg_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int CMD_W       = 4,
  parameter int NUM_TESTS   = 7,
  parameter int NUM_AES     = 3,
  parameter int WDOG_CYCLES = 4096,
  localparam int IDX_W      = (NUM_TESTS > 1) ? $clog2(NUM_TESTS) : 1,
  localparam int STAT_W     = IDX_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              eng_start,
  output logic [IDX_W-1:0]  eng_slot,
  output logic              eng_keysz,
  input  logic              eng_done,
  input  logic              eng_pass,
  input  logic              din_valid,
  input  logic [DATA_W-1:0] din_data,
  output logic              din_ready,
  output logic              core_in_valid,
  output logic [DATA_W-1:0] core_in_data,
  input  logic              core_in_ready,
  input  logic              core_out_valid,
  input  logic [DATA_W-1:0] core_out_data,
  output logic              core_out_ready,
  output logic              dout_valid,
  output logic [DATA_W-1:0] dout_data,
  input  logic              dout_ready,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_code,
  output logic              core_cmd_valid,
  output logic [CMD_W-1:0]  core_cmd_code,
  output logic [STAT_W-1:0] status
);
  sq_state_e        state;
  logic [IDX_W-1:0] slot_idx;
  logic [IDX_W-1:0] fail_idx;
  logic             wd_expired;
  logic             open;

  stg_watchdog #(.LIMIT(WDOG_CYCLES)) u_wdog (
    .clk     (clk),
    .rst_n   (rst_n),
    .armed   (state == SQ_WAIT),
    .expired (wd_expired)
  );

  stg_sequencer #(.NUM_TESTS(NUM_TESTS), .IDX_W(IDX_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .eng_done   (eng_done),
    .eng_pass   (eng_pass),
    .wd_expired (wd_expired),
    .state      (state),
    .slot_idx   (slot_idx),
    .fail_idx   (fail_idx)
  );

  assign eng_start = (state == SQ_RUN);
  assign eng_slot  = slot_idx;
  assign eng_keysz = key_tag(int'(slot_idx), NUM_AES);
  assign open      = (state == SQ_OPER);

  stg_stream_gate #(.W(DATA_W)) u_in_gate (
    .open      (open),
    .src_valid (din_valid),
    .src_data  (din_data),
    .src_ready (din_ready),
    .dst_valid (core_in_valid),
    .dst_data  (core_in_data),
    .dst_ready (core_in_ready)
  );

  stg_stream_gate #(.W(DATA_W)) u_out_gate (
    .open      (open),
    .src_valid (core_out_valid),
    .src_data  (core_out_data),
    .src_ready (core_out_ready),
    .dst_valid (dout_valid),
    .dst_data  (dout_data),
    .dst_ready (dout_ready)
  );

  assign core_cmd_valid = open & cmd_valid;
  assign core_cmd_code  = open ? cmd_code : '0;

  assign status = {fail_idx,
                   state == SQ_ERR,
                   open,
                   (state == SQ_RESET) || (state == SQ_RUN) || (state == SQ_WAIT)};
endmodule

// File: rtl/stg_checker.sv
module stg_checker #(
  parameter int IDX_W   = 3,
  parameter int NUM_AES = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             eng_start,
  input logic [IDX_W-1:0] eng_slot,
  input logic             eng_keysz,
  input logic [IDX_W+2:0] status,
  input logic             core_cmd_valid,
  input logic             core_in_valid,
  input logic             din_ready,
  input logic             dout_valid,
  input logic             core_out_ready
);
  a_r2_start_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  a_r3_key_tag: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> (eng_keysz == (int'(eng_slot) >= NUM_AES)));

  a_r5_closed_paths: assert property (@(posedge clk) disable iff (!rst_n)
    !status[1] |-> !(core_cmd_valid || core_in_valid || din_ready || dout_valid || core_out_ready));

  a_r7_oper_holds: assert property (@(posedge clk) disable iff (!rst_n)
    status[1] |=> status[1]);

  a_r8_one_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(status[2:0]) == 1);

  a_r9_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    status[2] |=> status[2] && $stable(status[IDX_W+2:3]));

  a_r9_no_start_in_error: assert property (@(posedge clk) disable iff (!rst_n)
    status[2] |-> !eng_start);
endmodule

bind selftest_gate stg_checker #(.IDX_W(IDX_W), .NUM_AES(NUM_AES)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .eng_start      (eng_start),
  .eng_slot       (eng_slot),
  .eng_keysz      (eng_keysz),
  .status         (status),
  .core_cmd_valid (core_cmd_valid),
  .core_in_valid  (core_in_valid),
  .din_ready      (din_ready),
  .dout_valid     (dout_valid),
  .core_out_ready (core_out_ready)
);

// File: tb/sim_selftest_gate.sv
`timescale 1ns/1ps
module sim_selftest_gate;
  localparam int DW   = 32;
  localparam int CW   = 4;
  localparam int NT   = 7;
  localparam int WDOG = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic eng_start, eng_keysz, eng_done, eng_pass;
  logic [2:0] eng_slot;
  logic din_valid, din_ready, core_in_valid, core_in_ready;
  logic [DW-1:0] din_data, core_in_data, core_out_data, dout_data;
  logic core_out_valid, core_out_ready, dout_valid, dout_ready;
  logic cmd_valid, core_cmd_valid;
  logic [CW-1:0] cmd_code, core_cmd_code;
  logic [5:0] status;

  always #5 clk = ~clk;

  selftest_gate #(.DATA_W(DW), .CMD_W(CW), .NUM_TESTS(NT), .NUM_AES(3), .WDOG_CYCLES(WDOG)) u0 (
    .clk(clk), .rst_n(rst_n),
    .eng_start(eng_start), .eng_slot(eng_slot), .eng_keysz(eng_keysz),
    .eng_done(eng_done), .eng_pass(eng_pass),
    .din_valid(din_valid), .din_data(din_data), .din_ready(din_ready),
    .core_in_valid(core_in_valid), .core_in_data(core_in_data), .core_in_ready(core_in_ready),
    .core_out_valid(core_out_valid), .core_out_data(core_out_data), .core_out_ready(core_out_ready),
    .dout_valid(dout_valid), .dout_data(dout_data), .dout_ready(dout_ready),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .core_cmd_valid(core_cmd_valid), .core_cmd_code(core_cmd_code),
    .status(status)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Engine stub configuration: latency 0 means the engine never answers.
  int  lat [NT];
  bit  pas [NT];
  bit  stray = 0;
  bit  pend = 0;
  int  pcnt = 0;
  int  pslot = 0;

  // Reference model: 0 reset, 1 request, 2 waiting, 3 operational, 4 error.
  int ms = 0, midx = 0, mwait = 0, mfidx = 0;
  int cyc = 0;

  initial begin
    eng_done = 0; eng_pass = 0;
    din_valid = 0; din_data = '0; core_in_ready = 0;
    core_out_valid = 0; core_out_data = '0; dout_ready = 0;
    cmd_valid = 0; cmd_code = '0;
  end

  always @(negedge clk) begin
    bit op;
    cyc++;
    din_valid      = cyc[0];
    din_data       = DW'(cyc * 3 + 1);
    core_in_ready  = cyc[1];
    core_out_valid = ~cyc[0];
    core_out_data  = DW'(cyc * 7 + 5);
    dout_ready     = cyc[2] | cyc[0];
    cmd_valid      = cyc[1] ^ cyc[2];
    cmd_code       = CW'(cyc);

    eng_done = 0; eng_pass = 0;
    if (!rst_n) begin
      pend = 0; ms = 0; midx = 0; mwait = 0; mfidx = 0;
    end else if (stray) begin
      stray = 0; eng_done = 1; eng_pass = 1;
    end else if (pend) begin
      pcnt--;
      if (pcnt == 0) begin
        pend = 0; eng_done = 1; eng_pass = pas[pslot];
      end
    end

    #1;
    op = (ms == 3);
    chk("R1/R2 start pulse", eng_start, ms == 1);
    if (ms == 1) begin
      chk("R2 slot order", eng_slot, midx);
      chk("R3 key-size tag", eng_keysz, midx >= 3);
    end
    chk("R11/R7 busy bit", status[0], ms <= 2);
    chk("R7 operational bit", status[1], op);
    chk("R8/R9 failed bit", status[2], ms == 4);
    chk("R8/R10 failing test", status[5:3], mfidx);
    chk("R5/R6 core_in_valid", core_in_valid, op & din_valid);
    chk("R5/R6 din_ready", din_ready, op & core_in_ready);
    chk("R5/R6 core_in_data", core_in_data, op ? din_data : 0);
    chk("R5/R6 dout_valid", dout_valid, op & core_out_valid);
    chk("R5/R6 core_out_ready", core_out_ready, op & dout_ready);
    chk("R5/R6 dout_data", dout_data, op ? core_out_data : 0);
    chk("R5/R6 core_cmd_valid", core_cmd_valid, op & cmd_valid);
    chk("R5/R6 core_cmd_code", core_cmd_code, op ? cmd_code : 0);

    if (rst_n && eng_start) begin
      pslot = int'(eng_slot);
      pcnt  = lat[pslot];
      pend  = (pcnt != 0);
    end

    if (rst_n) begin
      case (ms)
        0: ms = 1;
        1: begin ms = 2; mwait = 0; end
        2: begin
          mwait++;
          if (eng_done) begin
            if (!eng_pass) begin ms = 4; mfidx = midx; end
            else if (midx == NT - 1) ms = 3;
            else begin midx++; ms = 1; end
          end else if (mwait == WDOG) begin
            ms = 4; mfidx = midx;
          end
        end
        default: ;
      endcase
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic setup(input int l0, input int l1, input int l2, input int l3,
                       input int l4, input int l5, input int l6, input int failslot);
    lat[0] = l0; lat[1] = l1; lat[2] = l2; lat[3] = l3;
    lat[4] = l4; lat[5] = l5; lat[6] = l6;
    for (int i = 0; i < NT; i++) pas[i] = (i != failslot);
  endtask

  task automatic do_reset();
    @(posedge clk); #2;
    rst_n = 0;
    wait_cyc(3);
    chk("R11 status during reset", status, 6'b000001);
    rst_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    finish_run();
  end

  initial begin
    // All pass with mixed latencies, traffic toggling throughout.
    setup(1, 2, 3, 1, 4, 2, 5, -1);
    do_reset();
    wait_cyc(120);
    chk("R7 operational after full list", status, 6'b000010);
    stray = 1;
    wait_cyc(5);
    chk("R4 stray done while operational", status, 6'b000010);

    // Failure at a middle test.
    setup(2, 1, 1, 3, 2, 1, 1, 4);
    do_reset();
    wait_cyc(100);
    chk("R8 fail at test 4", status, {3'd4, 3'b100});
    stray = 1;
    wait_cyc(30);
    chk("R9 error ignores done and commands", status, {3'd4, 3'b100});

    // Reset clears error and reruns everything.
    setup(1, 1, 1, 1, 1, 1, 1, -1);
    do_reset();
    wait_cyc(60);
    chk("R11 rerun after error", status, 6'b000010);

    // Answer in the last allowed waiting cycle is accepted.
    setup(WDOG, 1, 1, 1, 1, 1, 1, -1);
    do_reset();
    wait_cyc(WDOG + 60);
    chk("R10 done on last allowed cycle", status, 6'b000010);

    // Hung engine at test 2.
    setup(1, 1, 0, 1, 1, 1, 1, -1);
    do_reset();
    wait_cyc(WDOG + 60);
    chk("R10 timeout at test 2", status, {3'd2, 3'b100});

    // Failure at the last and at the first test.
    setup(1, 1, 1, 1, 1, 1, 2, 6);
    do_reset();
    wait_cyc(60);
    chk("R8 fail at test 6", status, {3'd6, 3'b100});
    setup(3, 1, 1, 1, 1, 1, 1, 0);
    do_reset();
    wait_cyc(20);
    chk("R8 fail at test 0", status, {3'd0, 3'b100});

    wait_cyc(5);
    finish_run();
  end
endmodule